// File: doc/BRIEF.md
# Interrupt Request and Cycle Sequencer

This block sits beside the main control sequencer of a small accumulator machine. It watches the interrupt-enable flag and the two device-ready flags (input ready, output ready) and, while an instruction is executing, latches a pending-interrupt bit. When the next instruction cycle is about to start and that bit is set, the block takes over for three clocks and runs an interrupt cycle in place of the fetch.

The interrupt cycle saves the current program counter into a temporary register, writes it to memory at address 0, clears the program counter and then increments it, so the service routine begins at address 1. In the same last step, it clears the interrupt-enable flag, its own pending bit and the sequence counter. The service routine returns with an indirect branch through address 0. The block has no address register, program counter or memory of its own. It drives strobes that tell the surrounding datapath to clear, load, write or increment those registers, and it supplies the save address and the saved value.

Top module: `intr_cycle_seq`

## Requirements
- R1: When `execPhase`, `ienFlag` and at least one of `inFlag` or `outFlag` are all 1 at a rising clock edge outside an interrupt cycle, `intReq` is 1 from that edge on.
- R2: While `ienFlag` is 0, or both device flags are 0, `intReq` does not go from 0 to 1.
- R3: While `execPhase` is 0 (the fetch and decode steps), `intReq` does not go from 0 to 1, whatever the flags are.
- R4: In a cycle where `cycleStart` is 1 and `intReq` is 1, the first step runs combinationally: `clrAr`, `loadTr` and `intCycle` are 1, and the value on `pcIn` is captured at the edge that ends the cycle.
- R5: In the clock after the first step, `memWr` and `clrPc` are 1, `memAddr` is 0, and `memData` holds the captured program counter.
- R6: In the clock after that, `incPc`, `clrIen` and `clrSc` are 1, and `intReq` is 0 from the edge that ends this step, so the program counter settles at 1.
- R7: No strobe is active outside the three steps, at most one of `loadTr`, `memWr` or `incPc` is active in any cycle, and a `cycleStart` with `intReq` at 0 starts no interrupt cycle.
- R8: Reset (`rstN` at 0) clears the pending bit and the step state, and leaves every strobe at 0.
- R9: Because the enable flag is cleared in the last step, device flags that stay at 1 during execution afterwards do not raise `intReq` again until the enable flag is set again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| ienFlag | input | 1 | Interrupt-enable flag held by the surrounding control |
| inFlag | input | 1 | Input device has a character ready |
| outFlag | input | 1 | Output device is ready for a character |
| execPhase | input | 1 | Instruction is in its execute steps |
| cycleStart | input | 1 | Sequence counter is at step 0, so a new cycle starts now |
| pcIn | input | 12 | Current program counter |
| intReq | output | 1 | Pending interrupt bit |
| intCycle | output | 1 | An interrupt cycle step is active in this clock |
| clrAr | output | 1 | Clear the address register |
| loadTr | output | 1 | Load the temporary register from the program counter |
| memWr | output | 1 | Write `memData` to memory at `memAddr` |
| memAddr | output | 12 | Save address for the return address (always 0) |
| memData | output | 12 | Saved program counter |
| clrPc | output | 1 | Clear the program counter |
| incPc | output | 1 | Increment the program counter |
| clrIen | output | 1 | Clear the interrupt-enable flag |
| clrSc | output | 1 | Clear the sequence counter |

## Verification
The assertions check every cycle that the pending bit is only set by an enabled flag during execution, and that the three steps always follow one another in order with the right strobes. They also check that the saved value equals the program counter from the step before, that the write goes to address 0, and that the pending bit is gone after the last step. Only the bench scenarios show effects that reach past the block: the program counter ends at 1, memory address 0 holds the interrupted address, and flags left at 1 raise no second interrupt after the enable flag is cleared. The bench also shows that reset in the middle of a pending request drops it.

// File: rtl/intr_seq_pkg.sv
package intr_seq_pkg;

  typedef struct packed {
    logic clrAr;
    logic loadTr;
    logic memWr;
    logic clrPc;
    logic incPc;
    logic clrIen;
    logic clrPend;
    logic clrSc;
  } intStrobes_t;

  typedef enum logic [1:0] {
    STEP_IDLE = 2'd0,
    STEP_SAVE = 2'd1,
    STEP_VEC  = 2'd2
  } intStep_e;

endpackage

// File: rtl/intr_seq_ctrl.sv
module intr_seq_ctrl
  import intr_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ienFlag,
  input  logic        inFlag,
  input  logic        outFlag,
  input  logic        execPhase,
  input  logic        cycleStart,
  output logic        intReq,
  output logic        intCycle,
  output intStrobes_t strobes
);

  intStep_e stepQ, stepD;
  logic     pendQ;
  logic     firstStep;
  logic     raiseReq;

  // First step runs in place of fetch step 0, no idle bubble.
  assign firstStep = (stepQ == STEP_IDLE) && cycleStart && pendQ;
  assign raiseReq  = execPhase && ienFlag && (inFlag || outFlag);

  always_comb begin
    stepD = stepQ;
    case (stepQ)
      STEP_IDLE: if (firstStep) stepD = STEP_SAVE;
      STEP_SAVE: stepD = STEP_VEC;
      STEP_VEC:  stepD = STEP_IDLE;
      default:   stepD = STEP_IDLE;
    endcase
  end

  always_comb begin
    strobes         = '0;
    strobes.clrAr   = firstStep;
    strobes.loadTr  = firstStep;
    strobes.memWr   = (stepQ == STEP_SAVE);
    strobes.clrPc   = (stepQ == STEP_SAVE);
    strobes.incPc   = (stepQ == STEP_VEC);
    strobes.clrIen  = (stepQ == STEP_VEC);
    strobes.clrPend = (stepQ == STEP_VEC);
    strobes.clrSc   = (stepQ == STEP_VEC);
  end

  assign intCycle = firstStep || (stepQ != STEP_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepQ <= STEP_IDLE;
      pendQ <= 1'b0;
    end else begin
      stepQ <= stepD;
      // Clear wins; no new request is taken inside an interrupt cycle.
      if (strobes.clrPend)
        pendQ <= 1'b0;
      else if (raiseReq && !intCycle)
        pendQ <= 1'b1;
    end
  end

  assign intReq = pendQ;

endmodule

// File: rtl/intr_seq_dp.sv
module intr_seq_dp
  import intr_seq_pkg::*;
#(
  parameter int PC_W      = 12,
  parameter int ADDR_W    = 12,
  parameter int SAVE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  intStrobes_t       strobes,
  input  logic [PC_W-1:0]   pcIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   memData
);

  localparam logic [ADDR_W-1:0] SaveAddrC = ADDR_W'(SAVE_ADDR);

  logic [PC_W-1:0] trQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      trQ <= '0;
    else if (strobes.loadTr)
      trQ <= pcIn;
  end

  assign memAddr = SaveAddrC;
  assign memData = trQ;

endmodule

// File: rtl/intr_cycle_seq.sv
module intr_cycle_seq
  import intr_seq_pkg::*;
#(
  parameter int PC_W   = 12,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ienFlag,
  input  logic              inFlag,
  input  logic              outFlag,
  input  logic              execPhase,
  input  logic              cycleStart,
  input  logic [PC_W-1:0]   pcIn,
  output logic              intReq,
  output logic              intCycle,
  output logic              clrAr,
  output logic              loadTr,
  output logic              memWr,
  output logic [ADDR_W-1:0] memAddr,
  output logic [PC_W-1:0]   memData,
  output logic              clrPc,
  output logic              incPc,
  output logic              clrIen,
  output logic              clrSc
);

  intStrobes_t strobes;

  intr_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .ienFlag   (ienFlag),
    .inFlag    (inFlag),
    .outFlag   (outFlag),
    .execPhase (execPhase),
    .cycleStart(cycleStart),
    .intReq    (intReq),
    .intCycle  (intCycle),
    .strobes   (strobes)
  );

  intr_seq_dp #(.PC_W(PC_W), .ADDR_W(ADDR_W), .SAVE_ADDR(0)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .pcIn   (pcIn),
    .memAddr(memAddr),
    .memData(memData)
  );

  assign clrAr  = strobes.clrAr;
  assign loadTr = strobes.loadTr;
  assign memWr  = strobes.memWr;
  assign clrPc  = strobes.clrPc;
  assign incPc  = strobes.incPc;
  assign clrIen = strobes.clrIen;
  assign clrSc  = strobes.clrSc;

endmodule

// File: rtl/intr_cycle_seq_chk.sv
module intr_cycle_seq_chk #(
  parameter int PC_W   = 12,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              ienFlag,
  input logic              inFlag,
  input logic              outFlag,
  input logic              execPhase,
  input logic              cycleStart,
  input logic [PC_W-1:0]   pcIn,
  input logic              intReq,
  input logic              intCycle,
  input logic              clrAr,
  input logic              loadTr,
  input logic              memWr,
  input logic [ADDR_W-1:0] memAddr,
  input logic [PC_W-1:0]   memData,
  input logic              clrPc,
  input logic              incPc,
  input logic              clrIen,
  input logic              clrSc
);

  // R1: enabled flag during execution raises the pending bit
  p_raise_r1: assert property (@(posedge clk) disable iff (!rstN)
    (execPhase && ienFlag && (inFlag || outFlag) && !intCycle) |=> intReq);

  // R2: no enable or no flag, no new request
  p_no_raise_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!intReq && !(ienFlag && (inFlag || outFlag))) |=> !intReq);

  // R3: no new request during fetch steps
  p_no_fetch_raise_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!intReq && !execPhase) |=> !intReq);

  // R4: first step only with a pending request at a cycle start
  p_first_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    loadTr |-> (clrAr && intReq && cycleStart && intCycle));

  // R5: save step follows and carries the captured program counter
  p_save_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    loadTr |=> (memWr && clrPc && memData == $past(pcIn)));

  p_save_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    memWr |-> (memAddr == '0));

  // R6: vector step follows and drops the pending bit
  p_vec_step_r6: assert property (@(posedge clk) disable iff (!rstN)
    memWr |=> (incPc && clrIen && clrSc));

  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    clrIen |=> !intReq);

  // R7: steps are exclusive and strobes stay inside the cycle
  p_one_step_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadTr, memWr, incPc}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    !intCycle |-> !(clrAr || memWr || clrPc || incPc || clrIen || clrSc));

endmodule

bind intr_cycle_seq intr_cycle_seq_chk #(.PC_W(PC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_intr_cycle_seq.sv
module sim_intr_cycle_seq;

  localparam int CLK_P = 10;
  localparam int PC_W  = 12;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            inFlag = 1'b0, outFlag = 1'b0;
  logic            execPhase = 1'b0, cycleStart = 1'b0;
  logic            intReq, intCycle, clrAr, loadTr, memWr, clrPc, incPc, clrIen, clrSc;
  logic [11:0]     memAddr;
  logic [PC_W-1:0] memData;

  // Simple surrounding registers
  logic [PC_W-1:0] pcM = '0;
  logic [PC_W-1:0] mem0 = '0;
  logic            ienM = 1'b0;
  logic            pcSet = 1'b0, ienSet = 1'b0;
  logic [PC_W-1:0] pcVal = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    if (clrPc) pcM <= '0;
    else if (incPc) pcM <= pcM + 1'b1;
    else if (pcSet) pcM <= pcVal;
    if (clrIen) ienM <= 1'b0;
    else if (ienSet) ienM <= 1'b1;
    if (memWr && memAddr == '0) mem0 <= memData;
  end

  intr_cycle_seq u0 (
    .clk(clk), .rstN(rstN), .ienFlag(ienM), .inFlag(inFlag), .outFlag(outFlag),
    .execPhase(execPhase), .cycleStart(cycleStart), .pcIn(pcM),
    .intReq(intReq), .intCycle(intCycle), .clrAr(clrAr), .loadTr(loadTr),
    .memWr(memWr), .memAddr(memAddr), .memData(memData), .clrPc(clrPc),
    .incPc(incPc), .clrIen(clrIen), .clrSc(clrSc)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int strobeVec();
    return {clrAr, loadTr, memWr, clrPc, incPc, clrIen, clrSc};
  endfunction

  task automatic enableIen();
    @(negedge clk); ienSet = 1'b1;
    @(negedge clk); ienSet = 1'b0;
  endtask

  // One execute cycle with given flags
  task automatic execWith(input bit fIn, input bit fOut, input bit ex);
    @(negedge clk); inFlag = fIn; outFlag = fOut; execPhase = ex;
    @(negedge clk); inFlag = 1'b0; outFlag = 1'b0; execPhase = 1'b0;
  endtask

  // Runs the three steps and checks each; R must be pending on entry
  task automatic runIntr(input logic [PC_W-1:0] pc, input bit holdFlags);
    @(negedge clk); pcSet = 1'b1; pcVal = pc;
    @(negedge clk); pcSet = 1'b0; cycleStart = 1'b1;
    if (holdFlags) begin execPhase = 1'b1; inFlag = 1'b1; end
    #1;
    chk(clrAr && loadTr && intCycle, "R4 first step strobes", strobeVec(), 7'h60);
    @(negedge clk); cycleStart = 1'b0; #1;
    chk(memWr && clrPc && !incPc, "R5 save step strobes", strobeVec(), 7'h18);
    chk(memAddr == '0 && memData == pc, "R5 save address/data", memData, pc);
    @(negedge clk); #1;
    chk(incPc && clrIen && clrSc && !memWr, "R6 vector step strobes", strobeVec(), 7'h07);
    chk(pcM == '0, "R5 pc cleared", pcM, 0);
    @(negedge clk); #1;
    chk(!intReq, "R6 pending cleared", intReq, 0);
    chk(pcM == 1 && !ienM, "R6 pc at 1, enable cleared", pcM, 1);
    chk(mem0 == pc, "R5 return address saved", mem0, pc);
    chk(strobeVec() == 0 && !intCycle, "R7 quiet after cycle", strobeVec(), 0);
    execPhase = 1'b0; inFlag = 1'b0;
  endtask

  task automatic tReset();
    #1;
    chk(!intReq && strobeVec() == 0 && !intCycle, "R8 reset state", strobeVec(), 0);
  endtask

  task automatic tInputFlag();
    enableIen();
    execWith(1, 0, 1); #1;
    chk(intReq, "R1 input flag raises request", intReq, 1);
    runIntr(12'h123, 0);
    // R9: flags stay up but enable was cleared
    execWith(1, 1, 1); #1;
    chk(!intReq, "R9 no nested request", intReq, 0);
  endtask

  task automatic tOutputFlag();
    enableIen();
    execWith(0, 1, 1); #1;
    chk(intReq, "R1 output flag raises request", intReq, 1);
    runIntr(12'hFFF, 1);
  endtask

  task automatic tDisabled();
    execWith(1, 1, 1); #1;
    chk(!intReq, "R2 disabled enable blocks request", intReq, 0);
    enableIen();
    execWith(0, 0, 1); #1;
    chk(!intReq, "R2 no flag no request", intReq, 0);
    @(negedge clk); cycleStart = 1'b1; #1;
    chk(strobeVec() == 0 && !intCycle, "R7 start without request", strobeVec(), 0);
    @(negedge clk); cycleStart = 1'b0; #1;
    chk(strobeVec() == 0, "R7 still idle", strobeVec(), 0);
  endtask

  task automatic tFetch();
    execWith(1, 1, 0); #1;
    chk(!intReq, "R3 fetch steps ignore flags", intReq, 0);
  endtask

  task automatic tResetMid();
    execWith(1, 0, 1); #1;
    chk(intReq, "R1 request before reset", intReq, 1);
    @(negedge clk); rstN = 1'b0; #1;
    chk(!intReq, "R8 reset drops request", intReq, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk); cycleStart = 1'b1; #1;
    chk(strobeVec() == 0, "R8 no cycle after reset", strobeVec(), 0);
    @(negedge clk); cycleStart = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    tInputFlag();
    tOutputFlag();
    tDisabled();
    tFetch();
    tResetMid();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 5000);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule